// File: doc/BRIEF.md
# Shift, Rotate and Flag-Set Unit

This block carries out the bit-movement and flag-driven operations of a datapath. It rotates left or right, shifts left with zero fill, or shifts right with sign fill, on a W-bit operand (64 by default) by a variable amount. On every such move it records in the carry flag the final bit that left the operand. The same unit also produces the flag-derived results: a result of 1 or 0 that mirrors the carry, overflow or sign flag. It also runs the two flag-only operations that force the carry high or low.

The caller presents an operand, a count, a 4-bit operation code and the present flag values together with a valid strobe. On the next rising clock edge the unit registers the result and the new carry, and pulses a done signal for one cycle. When the strobe is low, the registered outputs keep their values. Instruction decode and register-file traffic happen elsewhere.

Top module: `shrot_unit`

## Requirements
- R1: After reset, while reset is held low (active-low), `res` is 0, `cf` is 0 and `done` is 0.
- R2: A request is taken only on a rising edge with `vld` high; `res` and `cf` then change one cycle later and `done` is high for exactly that cycle. With `vld` low, `res` and `cf` hold and `done` is 0.
- R3: Rotate-left (op 0) by k = count mod W moves bits toward the MSB, with bits leaving the top re-entering at bit 0; carry becomes the last bit that left, which lands at result bit 0.
- R4: Rotate-right (op 1) by k moves bits toward the LSB, with bits leaving bit 0 re-entering at the top; carry becomes the last bit that left, which lands at the result MSB.
- R5: Shift-left (op 2) by k fills the vacated low bits with zeros; carry becomes operand bit W-k.
- R6: Arithmetic shift-right (op 3) by k copies the operand sign bit into the vacated high bits; carry becomes operand bit k-1.
- R7: Only the low log2(W) bits of the count are used. When the whole count is zero, ops 0 to 3 return the operand unchanged, and the carry output equals `cf_in`.
- R8: For a non-zero count that is a multiple of W, both rotates return the operand unchanged, and carry takes the operand MSB for op 0 or the operand LSB for op 1. Both shifts return the operand unchanged, and carry equals `cf_in`.
- R9: Ops 4, 5 and 6 return a result whose bit 0 is `cf_in`, `of_in` or `sf_in` respectively, with all other bits zero; carry equals `cf_in`.
- R10: Op 7 sets carry to 1 and op 8 clears it; both leave `res` at its previous value.
- R11: Op codes 9 to 15 leave `res` and `cf` at their previous values, while `done` still pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| vld | input | 1 | Request strobe |
| op | input | 4 | Operation code |
| opnd | input | W | Operand |
| cnt | input | CNT_W | Shift or rotate amount |
| cf_in | input | 1 | Present carry flag |
| of_in | input | 1 | Present overflow flag |
| sf_in | input | 1 | Present sign flag |
| res | output | W | Registered result |
| cf | output | 1 | Registered carry flag |
| done | output | 1 | One-cycle pulse marking a fresh result |

## Verification
Every result and carry of this unit is due exactly one rising edge after the request, and `done` marks that same cycle. The bench drives each request just after a falling edge and compares `res`, `cf` and `done` at the next falling edge, half a period after the capturing edge. Idle cycles with `vld` low are mixed into the stream and checked at the same point, to confirm that the held values do not move. The expected values come from a bit-at-a-time model that tracks the carry through each single step, plus separate handling of the zero-count and whole-width-count cases.

// File: rtl/shrot_unit.sv
module shrot_unit #(
  parameter int W     = 64,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             vld,
  input  logic [3:0]       op,
  input  logic [W-1:0]     opnd,
  input  logic [CNT_W-1:0] cnt,
  input  logic             cf_in,
  input  logic             of_in,
  input  logic             sf_in,
  output logic [W-1:0]     res,
  output logic             cf,
  output logic             done
);
  localparam int SW = $clog2(W);

  localparam logic [3:0] OP_ROL  = 4'd0;
  localparam logic [3:0] OP_ROR  = 4'd1;
  localparam logic [3:0] OP_SHL  = 4'd2;
  localparam logic [3:0] OP_SAR  = 4'd3;
  localparam logic [3:0] OP_SETC = 4'd4;
  localparam logic [3:0] OP_SETO = 4'd5;
  localparam logic [3:0] OP_SETS = 4'd6;
  localparam logic [3:0] OP_STC  = 4'd7;
  localparam logic [3:0] OP_CLC  = 4'd8;

  logic [SW-1:0]  k;
  logic           cnt_nz, k_nz;
  logic [2*W-1:0] dbl, rol_w, ror_w;
  logic [W-1:0]   rol_r, ror_r;
  logic [W:0]     shl_w, sar_w;
  logic [W-1:0]   nxt_res;
  logic           nxt_cf;

  assign k      = cnt[SW-1:0];
  assign cnt_nz = |cnt;
  assign k_nz   = |k;
  assign dbl    = {opnd, opnd};
  assign rol_w  = dbl << k;
  assign ror_w  = dbl >> k;
  assign rol_r  = rol_w[2*W-1:W];
  assign ror_r  = ror_w[W-1:0];
  assign shl_w  = {1'b0, opnd} << k;
  assign sar_w  = $signed({opnd, 1'b0}) >>> k;

  always_comb begin
    nxt_res = res;
    nxt_cf  = cf;
    unique case (op)
      OP_ROL: begin
        if (!cnt_nz)     begin nxt_res = opnd;  nxt_cf = cf_in;      end
        else if (!k_nz)  begin nxt_res = opnd;  nxt_cf = opnd[W-1];  end
        else             begin nxt_res = rol_r; nxt_cf = rol_r[0];   end
      end
      OP_ROR: begin
        if (!cnt_nz)     begin nxt_res = opnd;  nxt_cf = cf_in;      end
        else if (!k_nz)  begin nxt_res = opnd;  nxt_cf = opnd[0];    end
        else             begin nxt_res = ror_r; nxt_cf = ror_r[W-1]; end
      end
      OP_SHL: begin
        if (!k_nz)       begin nxt_res = opnd;          nxt_cf = cf_in;    end
        else             begin nxt_res = shl_w[W-1:0];  nxt_cf = shl_w[W]; end
      end
      OP_SAR: begin
        if (!k_nz)       begin nxt_res = opnd;          nxt_cf = cf_in;    end
        else             begin nxt_res = sar_w[W:1];    nxt_cf = sar_w[0]; end
      end
      OP_SETC: begin nxt_res = '0; nxt_res[0] = cf_in; nxt_cf = cf_in; end
      OP_SETO: begin nxt_res = '0; nxt_res[0] = of_in; nxt_cf = cf_in; end
      OP_SETS: begin nxt_res = '0; nxt_res[0] = sf_in; nxt_cf = cf_in; end
      OP_STC:  nxt_cf = 1'b1;
      OP_CLC:  nxt_cf = 1'b0;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res  <= '0;
      cf   <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= vld;
      if (vld) begin
        res <= nxt_res;
        cf  <= nxt_cf;
      end
    end
  end
endmodule

module shrot_unit_chk #(
  parameter int W     = 64,
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             vld,
  input logic [3:0]       op,
  input logic [W-1:0]     opnd,
  input logic [CNT_W-1:0] cnt,
  input logic             cf_in,
  input logic             of_in,
  input logic             sf_in,
  input logic [W-1:0]     res,
  input logic             cf,
  input logic             done
);
  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !vld |=> ($stable(res) && $stable(cf) && !done));

  // R2
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vld |=> done);

  // R7
  zero_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vld && op < 4'd4 && cnt == '0) |=> (res == $past(opnd) && cf == $past(cf_in)));

  // R9
  set_on_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vld && op == 4'd4) |=> (res == {{(W-1){1'b0}}, $past(cf_in)} && cf == $past(cf_in)));

  // R10
  force_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vld && op == 4'd7) |=> (cf && $stable(res)));

  // R10
  clear_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vld && op == 4'd8) |=> (!cf && $stable(res)));

  // R11
  unused_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vld && op > 4'd8) |=> ($stable(res) && $stable(cf)));
endmodule

bind shrot_unit shrot_unit_chk #(.W(W), .CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .vld(vld), .op(op), .opnd(opnd), .cnt(cnt),
  .cf_in(cf_in), .of_in(of_in), .sf_in(sf_in), .res(res), .cf(cf), .done(done)
);

// File: tb/shrot_unit_tb_top.sv
`timescale 1ns/1ps
module shrot_unit_tb_top;
  localparam int W     = 64;
  localparam int CNT_W = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             vld = 1'b0;
  logic [3:0]       op = '0;
  logic [W-1:0]     opnd = '0;
  logic [CNT_W-1:0] cnt = '0;
  logic             cf_in = 1'b0, of_in = 1'b0, sf_in = 1'b0;
  logic [W-1:0]     res;
  logic             cf, done;

  int n_chk = 0, n_bad = 0;
  logic [W-1:0] m_res = '0;
  logic         m_cf  = 1'b0;

  always #2 clk = ~clk;

  shrot_unit #(.W(W), .CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .vld(vld), .op(op), .opnd(opnd), .cnt(cnt),
    .cf_in(cf_in), .of_in(of_in), .sf_in(sf_in), .res(res), .cf(cf), .done(done)
  );

  function automatic logic [W:0] model(input logic [3:0] o, input logic [W-1:0] a,
      input logic [CNT_W-1:0] c, input logic ci, input logic oi, input logic si,
      input logic [W-1:0] pr, input logic pc);
    int k;
    logic [W-1:0] r;
    logic co;
    k = int'(c) % W;
    r = a;
    co = ci;
    case (o)
      4'd0, 4'd1: begin
        if (c == '0) return {ci, a};
        if (k == 0) return {(o == 4'd0) ? a[W-1] : a[0], a};
        for (int i = 0; i < k; i++) begin
          if (o == 4'd0) begin co = r[W-1]; r = {r[W-2:0], co}; end
          else           begin co = r[0];   r = {co, r[W-1:1]}; end
        end
        return {co, r};
      end
      4'd2, 4'd3: begin
        if (k == 0) return {ci, a};
        for (int i = 0; i < k; i++) begin
          if (o == 4'd2) begin co = r[W-1]; r = {r[W-2:0], 1'b0}; end
          else           begin co = r[0];   r = {r[W-1], r[W-1:1]}; end
        end
        return {co, r};
      end
      4'd4: return {ci, {(W-1){1'b0}}, ci};
      4'd5: return {ci, {(W-1){1'b0}}, oi};
      4'd6: return {ci, {(W-1){1'b0}}, si};
      4'd7: return {1'b1, pr};
      4'd8: return {1'b0, pr};
      default: return {pc, pr};
    endcase
  endfunction

  task automatic check(input string tag, input logic [W-1:0] er, input logic ec, input logic ed);
    n_chk++;
    if (res !== er || cf !== ec || done !== ed) begin
      n_bad++;
      $display("FAIL %s: res=%h cf=%b done=%b expected res=%h cf=%b done=%b",
               tag, res, cf, done, er, ec, ed);
    end
  endtask

  task automatic step(input string tag, input logic v, input logic [3:0] o,
      input logic [W-1:0] a, input logic [CNT_W-1:0] c,
      input logic ci, input logic oi, input logic si);
    logic [W:0] m;
    vld = v; op = o; opnd = a; cnt = c; cf_in = ci; of_in = oi; sf_in = si;
    if (v) begin
      m = model(o, a, c, ci, oi, si, m_res, m_cf);
      m_res = m[W-1:0];
      m_cf  = m[W];
    end
    @(negedge clk);
    check(tag, m_res, m_cf, v);
  endtask

  function automatic string tag_of(input logic [3:0] o, input logic [CNT_W-1:0] c);
    if (o <= 4'd3 && c[5:0] == 6'd0) return (c == '0) ? "R7" : "R8";
    case (o)
      4'd0: return "R3";
      4'd1: return "R4";
      4'd2: return "R5";
      4'd3: return "R6";
      4'd4, 4'd5, 4'd6: return "R9";
      4'd7, 4'd8: return "R10";
      default: return "R11";
    endcase
  endfunction

  initial begin
    #(200000 * 4);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1357));
    repeat (3) @(negedge clk);
    check("R1", '0, 1'b0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", '0, 1'b0, 1'b0);

    step("R3", 1, 4'd0, 64'h8000_0000_0000_0001, 8'd1, 0, 0, 0);
    step("R3", 1, 4'd0, 64'h0123_4567_89AB_CDEF, 8'd63, 1, 0, 0);
    step("R4", 1, 4'd1, 64'h0000_0000_0000_0003, 8'd1, 0, 0, 0);
    step("R4", 1, 4'd1, 64'hF000_0000_0000_0010, 8'd5, 1, 0, 0);
    step("R5", 1, 4'd2, 64'hC000_0000_0000_0000, 8'd1, 0, 0, 0);
    step("R5", 1, 4'd2, 64'h4000_0000_0000_0000, 8'd63, 1, 0, 0);
    step("R6", 1, 4'd3, 64'h8000_0000_0000_0002, 8'd2, 0, 0, 0);
    step("R6", 1, 4'd3, 64'h8000_0000_0000_0000, 8'd63, 1, 0, 0);
    step("R7", 1, 4'd0, 64'hDEAD_BEEF_0000_0001, 8'd0, 1, 0, 0);
    step("R7", 1, 4'd3, 64'h8000_0000_0000_0001, 8'd0, 0, 0, 0);
    step("R7", 1, 4'd2, 64'h0000_0000_0000_0001, 8'd65, 0, 0, 0);
    step("R8", 1, 4'd0, 64'h8000_0000_0000_0000, 8'd64, 0, 0, 0);
    step("R8", 1, 4'd1, 64'h0000_0000_0000_0001, 8'd128, 0, 0, 0);
    step("R8", 1, 4'd0, 64'h7FFF_FFFF_FFFF_FFFE, 8'd192, 1, 0, 0);
    step("R8", 1, 4'd2, 64'hFFFF_FFFF_FFFF_FFFF, 8'd64, 0, 0, 0);
    step("R8", 1, 4'd3, 64'hFFFF_FFFF_FFFF_FFFF, 8'd128, 1, 0, 0);
    step("R9", 1, 4'd4, 64'hFFFF_FFFF_FFFF_FFFF, 8'd3, 1, 0, 0);
    step("R9", 1, 4'd5, 64'hFFFF_FFFF_FFFF_FFFF, 8'd3, 0, 1, 0);
    step("R9", 1, 4'd6, 64'hFFFF_FFFF_FFFF_FFFF, 8'd3, 0, 1, 0);
    step("R9", 1, 4'd6, '0, 8'd3, 0, 0, 1);
    step("R10", 1, 4'd8, 64'h1234, 8'd1, 1, 1, 1);
    step("R10", 1, 4'd7, 64'h5678, 8'd1, 0, 0, 0);
    step("R11", 1, 4'd12, 64'h9999, 8'd7, 0, 1, 1);
    step("R11", 1, 4'd15, 64'hAAAA, 8'd9, 0, 0, 0);
    step("R2", 0, 4'd0, 64'hFFFF, 8'd3, 0, 0, 0);
    step("R2", 0, 4'd7, 64'h0, 8'd0, 0, 0, 0);

    for (int i = 0; i < 3000; i++) begin
      logic [3:0] o;
      logic [CNT_W-1:0] c;
      logic v;
      v = ($urandom % 4) != 0;
      o = 4'($urandom % 16);
      c = ($urandom % 8 == 0) ? CNT_W'(64 * ($urandom % 4)) : CNT_W'($urandom);
      step(v ? tag_of(o, c) : "R2", v, o, {$urandom, $urandom}, c,
           1'($urandom), 1'($urandom), 1'($urandom));
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule